// File: doc/BRIEF.md
# Pipelined NVM Command Sequencer

This block accepts program and erase requests for an on-chip nonvolatile array and turns them into timed control enables for the array and its high-voltage supply. A requester presents an operation code, a region select, a byte address and a 16-bit data word. The block checks the request and holds it in a single waiting slot. A second request can therefore be queued while the first one is running. For an erase, the block reduces the address to the base of the sector it falls in. The region and the block-size parameter set the sector size.

The supply and the cells are not modelled. The block drives `hv_en` while high voltage is needed, `prog_en` while one word is being written, and `erase_en` while an erase runs. Every duration is a count of ticks. A divider register that can be written only once sets the tick rate. When a queued word program lands in the same row of the main region as the word being written, the sequencer starts the next word straight away. High voltage stays on between the two words, so both the ramp-down and the ramp-up are skipped.

State machine: `S_IDLE` (nothing active), `S_RAMP_UP` (high voltage rising), `S_PROG` (one word being written), `S_ERASE` (sector or mass erase), `S_RAMP_DN` (high voltage falling). The transitions are:

- IDLE→RAMP_UP when the slot holds a request. The request moves to the active register.
- RAMP_UP→PROG or RAMP_UP→ERASE after T_RAMP ticks, chosen by the operation.
- PROG→PROG (the chain transition) when the word is done and the slot holds a same-row main-region program.
- PROG→RAMP_DN when the word is done and no chain is possible.
- ERASE→RAMP_DN after T_ERS ticks.
- RAMP_DN→IDLE after T_RAMP ticks.

Top module: `nvm_cmd_seq`

## Requirements
- R1: Writing `div_wdata` with `div_wr` sets `div_loaded`. Bit 6 selects an extra divide-by-8 and bits 5:0 hold D, so one tick is (D+1)·(bit6 ? 8 : 1) clock cycles. Bit 7 of the write is ignored. Any write after the first one is ignored until reset.
- R2: A request presented while `div_loaded` is low is rejected. It sets `access_err`, and no enable is driven.
- R3: Operation codes are 1 = word program, 2 = sector erase and 3 = mass erase. Code 0 is rejected, and so is a program to an odd address. Both set `access_err` without executing.
- R4: `access_err` stays set until `err_clr` is pulsed.
- R5: An erase shows its resolved base on `arr_addr`. In the main region (`cmd_region`=0) the base is aligned to 512 bytes, or 1024 when LARGE_BLK=1. In the data region (`cmd_region`=1) it is aligned to 4 bytes. A mass erase shows 0. A program shows its own address.
- R6: `buf_empty` is high while the waiting slot is free. A request is taken on a clock edge where `cmd_valid` and `buf_empty` are both high, including while another operation runs.
- R7: `all_done` is high only when nothing is active and the slot is empty.
- R8: An isolated operation holds `hv_en` for T_RAMP ticks before its enable rises. It then holds `prog_en` for T_PGM ticks or `erase_en` for T_ERS ticks. After that it spends T_RAMP ticks with `hv_en` low before `all_done` returns.
- R9: A queued main-region program in the same row (64 bytes, or 128 when LARGE_BLK=1) starts as the current word ends. `hv_en` then rises only once across both words, and neither ramp is repeated between them.
- R10: A queued program to a different row does not chain. High voltage ramps down and then up again.
- R11: Programs in the data region never chain, even to the same row.
- R12: An erase queued behind a program does not chain. High voltage ramps down and then up again.
- R13: `prog_en` and `erase_en` are never high together, and either one implies `hv_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_wr | input | 1 | Divider register write strobe |
| div_wdata | input | 8 | Divider write value (bit6 prescale, bits5:0 divisor) |
| div_loaded | output | 1 | Divider has been written |
| cmd_valid | input | 1 | Request present |
| cmd_op | input | 2 | Operation code |
| cmd_region | input | 1 | 0 main region, 1 data region |
| cmd_addr | input | AW | Byte address |
| cmd_data | input | DW | Word to program |
| err_clr | input | 1 | Clears the access error |
| buf_empty | output | 1 | Waiting slot is free |
| all_done | output | 1 | No active or waiting operation |
| access_err | output | 1 | Sticky rejection flag |
| hv_en | output | 1 | High-voltage enable |
| prog_en | output | 1 | Word-program enable |
| erase_en | output | 1 | Erase enable |
| arr_region | output | 1 | Region of the active operation |
| arr_addr | output | AW | Resolved address of the active operation |
| arr_data | output | DW | Data of the active operation |

## Verification
The bench targets the chain decision with four kinds of queued pairs: same row, next row, data region and program followed by erase. A sequencer that compared the wrong address bits, or ignored the region, would show a different number of `hv_en` rising edges or a gap in `prog_en`.

Each kind of erase is checked for its resolved base, because a wrong mask would place the erase in a neighbouring sector.

Ramp, program and erase lengths are measured in cycles under two divider settings, with and without the prescaler. A divider that counted one tick short, or that accepted a second write, would change every one of those lengths.

Rejected requests (before the divider is loaded, odd address, code 0) are checked for a raised error flag and a complete absence of enables.

// File: rtl/nvm_seq_pkg.sv
package nvm_seq_pkg;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_PROG = 2'd1,
        OP_SECT = 2'd2,
        OP_MASS = 2'd3
    } nvm_op_e;

    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_RAMP_UP = 3'd1,
        S_PROG    = 3'd2,
        S_ERASE   = 3'd3,
        S_RAMP_DN = 3'd4
    } seq_state_e;

    typedef struct packed {
        nvm_op_e op;
        logic    region;
    } req_kind_t;

endpackage

// File: rtl/nvm_clk_div.sv
module nvm_clk_div #(
    parameter int DIV_W = 6,
    parameter int PRE_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [7:0]       wdata,
    input  logic             restart,
    output logic             loaded,
    output logic             tick
);
    localparam logic [PRE_W-1:0] PRE_LAST = '1;

    logic             pre_sel;
    logic [DIV_W-1:0] div_val;
    logic [PRE_W-1:0] pre_cnt;
    logic [DIV_W-1:0] div_cnt;
    logic             pstep;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loaded  <= 1'b0;
            pre_sel <= 1'b0;
            div_val <= '0;
        end else if (wr && !loaded) begin
            loaded  <= 1'b1;
            pre_sel <= wdata[6];
            div_val <= wdata[DIV_W-1:0];
        end
    end

    always_comb begin
        pstep = !pre_sel || (pre_cnt == PRE_LAST);
        tick  = loaded && pstep && (div_cnt == div_val);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            pre_cnt <= '0;
            div_cnt <= '0;
        end else if (loaded) begin
            pre_cnt <= pre_cnt + 1'b1;
            if (pstep) begin
                div_cnt <= tick ? '0 : div_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/nvm_phase_tmr.sv
module nvm_phase_tmr #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          done
);
    logic [CW-1:0] cnt;

    always_comb done = tick && (cnt == limit - 1'b1);

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= done ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/nvm_cmd_buf.sv
module nvm_cmd_buf
    import nvm_seq_pkg::*;
#(
    parameter int AW       = 16,
    parameter int DW       = 16,
    parameter int SECT_LG  = 9,
    parameter int DSECT_LG = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [1:0]    in_op,
    input  logic          in_region,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_data,
    input  logic          div_loaded,
    input  logic          err_clr,
    input  logic          take,
    output logic          pend_valid,
    output req_kind_t     pend_kind,
    output logic [AW-1:0] pend_addr,
    output logic [DW-1:0] pend_data,
    output logic          access_err
);
    localparam logic [AW-1:0] MAIN_MASK = AW'((1 << SECT_LG) - 1);
    localparam logic [AW-1:0] DATA_MASK = AW'((1 << DSECT_LG) - 1);

    nvm_op_e       op_in;
    logic          accept;
    logic          bad;
    logic [AW-1:0] base;

    always_comb begin
        op_in  = nvm_op_e'(in_op);
        accept = in_valid && !pend_valid;
        bad    = !div_loaded || (op_in == OP_NONE) ||
                 ((op_in == OP_PROG) && in_addr[0]);
        unique case (op_in)
            OP_SECT: base = in_region ? (in_addr & ~DATA_MASK)
                                      : (in_addr & ~MAIN_MASK);
            OP_MASS: base = '0;
            default: base = in_addr;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_kind  <= '{op: OP_NONE, region: 1'b0};
            pend_addr  <= '0;
            pend_data  <= '0;
        end else begin
            if (take) begin
                pend_valid <= 1'b0;
            end
            if (accept && !bad) begin
                pend_valid <= 1'b1;
                pend_kind  <= '{op: op_in, region: in_region};
                pend_addr  <= base;
                pend_data  <= in_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            access_err <= 1'b0;
        end else if (accept && bad) begin
            access_err <= 1'b1;
        end else if (err_clr) begin
            access_err <= 1'b0;
        end
    end

endmodule

// File: rtl/nvm_seq_fsm.sv
module nvm_seq_fsm
    import nvm_seq_pkg::*;
#(
    parameter int AW     = 16,
    parameter int DW     = 16,
    parameter int ROW_LG = 6,
    parameter int CW     = 8,
    parameter int T_RAMP = 3,
    parameter int T_PGM  = 4,
    parameter int T_ERS  = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pend_valid,
    input  req_kind_t     pend_kind,
    input  logic [AW-1:0] pend_addr,
    input  logic [DW-1:0] pend_data,
    input  logic          tmr_done,
    output logic          take,
    output logic          tmr_restart,
    output logic [CW-1:0] tmr_limit,
    output logic          busy,
    output logic          hv_en,
    output logic          prog_en,
    output logic          erase_en,
    output logic          act_region,
    output logic [AW-1:0] act_addr,
    output logic [DW-1:0] act_data
);
    seq_state_e state_q, state_d;
    nvm_op_e    act_op;
    logic       chain_ok;
    logic       chain;

    always_comb begin
        chain_ok = pend_valid && (pend_kind.op == OP_PROG) &&
                   !pend_kind.region && !act_region &&
                   (pend_addr[AW-1:ROW_LG] == act_addr[AW-1:ROW_LG]);
    end

    // next state
    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        chain   = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (pend_valid) begin
                    state_d = S_RAMP_UP;
                    take    = 1'b1;
                end
            end
            S_RAMP_UP: begin
                if (tmr_done) begin
                    state_d = (act_op == OP_PROG) ? S_PROG : S_ERASE;
                end
            end
            S_PROG: begin
                if (tmr_done) begin
                    if (chain_ok) begin
                        take  = 1'b1;
                        chain = 1'b1;
                    end else begin
                        state_d = S_RAMP_DN;
                    end
                end
            end
            S_ERASE: begin
                if (tmr_done) state_d = S_RAMP_DN;
            end
            S_RAMP_DN: begin
                if (tmr_done) state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
        tmr_restart = (state_d != state_q) || chain;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_op     <= OP_NONE;
            act_region <= 1'b0;
            act_addr   <= '0;
            act_data   <= '0;
        end else if (take) begin
            act_op     <= pend_kind.op;
            act_region <= pend_kind.region;
            act_addr   <= pend_addr;
            act_data   <= pend_data;
        end
    end

    // outputs
    always_comb begin
        busy      = 1'b1;
        hv_en     = 1'b0;
        prog_en   = 1'b0;
        erase_en  = 1'b0;
        tmr_limit = CW'(T_RAMP);
        unique case (state_q)
            S_IDLE:    busy = 1'b0;
            S_RAMP_UP: hv_en = 1'b1;
            S_PROG: begin
                hv_en     = 1'b1;
                prog_en   = 1'b1;
                tmr_limit = CW'(T_PGM);
            end
            S_ERASE: begin
                hv_en     = 1'b1;
                erase_en  = 1'b1;
                tmr_limit = CW'(T_ERS);
            end
            S_RAMP_DN: tmr_limit = CW'(T_RAMP);
            default:   busy = 1'b0;
        endcase
    end

endmodule

// File: rtl/nvm_cmd_seq.sv
module nvm_cmd_seq
    import nvm_seq_pkg::*;
#(
    parameter int AW        = 16,
    parameter int DW        = 16,
    parameter bit LARGE_BLK = 1'b0,
    parameter int T_RAMP    = 3,
    parameter int T_PGM     = 4,
    parameter int T_ERS     = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          div_wr,
    input  logic [7:0]    div_wdata,
    output logic          div_loaded,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic          cmd_region,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_data,
    input  logic          err_clr,
    output logic          buf_empty,
    output logic          all_done,
    output logic          access_err,
    output logic          hv_en,
    output logic          prog_en,
    output logic          erase_en,
    output logic          arr_region,
    output logic [AW-1:0] arr_addr,
    output logic [DW-1:0] arr_data
);
    localparam int SECT_LG  = LARGE_BLK ? 10 : 9;
    localparam int ROW_LG   = LARGE_BLK ? 7 : 6;
    localparam int DSECT_LG = 2;
    localparam int T_MAX    = (T_ERS > T_PGM) ? ((T_ERS > T_RAMP) ? T_ERS : T_RAMP)
                                              : ((T_PGM > T_RAMP) ? T_PGM : T_RAMP);
    localparam int CW       = $clog2(T_MAX + 1);

    logic          tick;
    logic          tmr_done;
    logic          tmr_restart;
    logic [CW-1:0] tmr_limit;
    logic          take;
    logic          busy;
    logic          pend_valid;
    req_kind_t     pend_kind;
    logic [AW-1:0] pend_addr;
    logic [DW-1:0] pend_data;

    nvm_clk_div #(.DIV_W(6), .PRE_W(3)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (div_wr),
        .wdata   (div_wdata),
        .restart (tmr_restart),
        .loaded  (div_loaded),
        .tick    (tick)
    );

    nvm_phase_tmr #(.CW(CW)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (tmr_restart),
        .tick    (tick),
        .limit   (tmr_limit),
        .done    (tmr_done)
    );

    nvm_cmd_buf #(
        .AW(AW), .DW(DW), .SECT_LG(SECT_LG), .DSECT_LG(DSECT_LG)
    ) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (cmd_valid),
        .in_op      (cmd_op),
        .in_region  (cmd_region),
        .in_addr    (cmd_addr),
        .in_data    (cmd_data),
        .div_loaded (div_loaded),
        .err_clr    (err_clr),
        .take       (take),
        .pend_valid (pend_valid),
        .pend_kind  (pend_kind),
        .pend_addr  (pend_addr),
        .pend_data  (pend_data),
        .access_err (access_err)
    );

    nvm_seq_fsm #(
        .AW(AW), .DW(DW), .ROW_LG(ROW_LG), .CW(CW),
        .T_RAMP(T_RAMP), .T_PGM(T_PGM), .T_ERS(T_ERS)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .pend_valid  (pend_valid),
        .pend_kind   (pend_kind),
        .pend_addr   (pend_addr),
        .pend_data   (pend_data),
        .tmr_done    (tmr_done),
        .take        (take),
        .tmr_restart (tmr_restart),
        .tmr_limit   (tmr_limit),
        .busy        (busy),
        .hv_en       (hv_en),
        .prog_en     (prog_en),
        .erase_en    (erase_en),
        .act_region  (arr_region),
        .act_addr    (arr_addr),
        .act_data    (arr_data)
    );

    always_comb begin
        buf_empty = !pend_valid;
        all_done  = !busy && !pend_valid;
    end

endmodule

// File: rtl/nvm_cmd_seq_chk.sv
module nvm_cmd_seq_chk #(
    parameter int AW     = 16,
    parameter int ROW_LG = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          div_loaded,
    input logic          err_clr,
    input logic          buf_empty,
    input logic          all_done,
    input logic          access_err,
    input logic          hv_en,
    input logic          prog_en,
    input logic          erase_en,
    input logic          arr_region,
    input logic [AW-1:0] arr_addr
);
    // R13
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_en, erase_en}));

    // R13
    hv_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_en || erase_en) |-> hv_en);

    // R2
    hv_needs_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hv_en) |-> div_loaded);

    // R3
    prog_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_en |-> !arr_addr[0]);

    // R4
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (access_err && !err_clr) |=> access_err);

    // R5
    data_sect_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_en && arr_region) |-> (arr_addr[1:0] == 2'b00));

    // R1
    div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_loaded |=> div_loaded);

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        all_done |-> (!hv_en && buf_empty));

    // R9
    chain_same_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_en && $past(prog_en) && (arr_addr != $past(arr_addr)))
        |-> (!arr_region && (arr_addr[AW-1:ROW_LG] == $past(arr_addr[AW-1:ROW_LG]))));

endmodule

bind nvm_cmd_seq nvm_cmd_seq_chk #(.AW(AW), .ROW_LG(ROW_LG)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .div_loaded (div_loaded),
    .err_clr    (err_clr),
    .buf_empty  (buf_empty),
    .all_done   (all_done),
    .access_err (access_err),
    .hv_en      (hv_en),
    .prog_en    (prog_en),
    .erase_en   (erase_en),
    .arr_region (arr_region),
    .arr_addr   (arr_addr)
);

// File: tb/tb_nvm_cmd_seq.sv
`timescale 1ns/1ps
module tb_nvm_cmd_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        div_wr = 1'b0;
    logic [7:0]  div_wdata = '0;
    logic        div_loaded;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic        cmd_region = 1'b0;
    logic [15:0] cmd_addr = '0;
    logic [15:0] cmd_data = '0;
    logic        err_clr = 1'b0;
    logic        buf_empty, all_done, access_err, hv_en, prog_en, erase_en, arr_region;
    logic [15:0] arr_addr, arr_data;

    always #2 clk = ~clk;

    nvm_cmd_seq dut (
        .clk(clk), .rst_n(rst_n), .div_wr(div_wr), .div_wdata(div_wdata),
        .div_loaded(div_loaded), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_region(cmd_region), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .err_clr(err_clr), .buf_empty(buf_empty), .all_done(all_done),
        .access_err(access_err), .hv_en(hv_en), .prog_en(prog_en),
        .erase_en(erase_en), .arr_region(arr_region), .arr_addr(arr_addr),
        .arr_data(arr_data)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // negedge monitor
    logic        mon_clr = 1'b0;
    int          pgm_cyc, ers_cyc, hv_rises, hv_only, busy_nohv;
    logic [15:0] seen_addr;
    logic        hv_prev;
    always @(negedge clk) begin
        if (mon_clr) begin
            pgm_cyc = 0; ers_cyc = 0; hv_rises = 0; hv_only = 0; busy_nohv = 0;
            seen_addr = 16'hFFFF; hv_prev = hv_en;
        end else begin
            if (prog_en) pgm_cyc++;
            if (erase_en) ers_cyc++;
            if (prog_en || erase_en) seen_addr = arr_addr;
            if (hv_en && !hv_prev) hv_rises++;
            if (hv_en && !prog_en && !erase_en) hv_only++;
            if (!all_done && !hv_en) busy_nohv++;
            hv_prev = hv_en;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cmd_valid = 1'b0; div_wr = 1'b0; err_clr = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic clr_mon();
        mon_clr = 1'b1;
        @(posedge clk); #1;
        mon_clr = 1'b0;
    endtask

    task automatic write_div(input logic [7:0] v);
        div_wr = 1'b1; div_wdata = v;
        @(posedge clk); #1;
        div_wr = 1'b0;
    endtask

    task automatic issue(input logic [1:0] op, input logic rg,
                         input logic [15:0] a, input logic [15:0] d);
        int guard = 0;
        while (!buf_empty && guard < 2000) begin
            @(posedge clk); #1; guard++;
        end
        cmd_valid = 1'b1; cmd_op = op; cmd_region = rg; cmd_addr = a; cmd_data = d;
        @(posedge clk); #1;
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done();
        int guard = 0;
        do begin
            @(negedge clk); guard++;
        end while (!all_done && guard < 5000);
        @(posedge clk); #1;
    endtask

    task automatic clear_err();
        err_clr = 1'b1;
        @(posedge clk); #1;
        err_clr = 1'b0;
    endtask

    typedef struct packed {
        logic [1:0]  op;
        logic        rg;
        logic [15:0] addr;
        logic        exp_err;
        logic [15:0] exp_addr;
        logic [7:0]  exp_pgm;
        logic [7:0]  exp_ers;
    } vec_t;

    // divider D=1, no prescale: one tick = 2 cycles; ramp 6, program 8, erase 20
    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 1'b0, 16'h1234, 1'b0, 16'h1234, 8'd8,  8'd0},   // R5 program keeps address
        '{2'd2, 1'b0, 16'h13FE, 1'b0, 16'h1200, 8'd0,  8'd20},  // R5 main sector base
        '{2'd2, 1'b1, 16'h0037, 1'b0, 16'h0034, 8'd0,  8'd20},  // R5 data sector base
        '{2'd3, 1'b0, 16'h5555, 1'b0, 16'h0000, 8'd0,  8'd20},  // R5 mass erase
        '{2'd1, 1'b0, 16'h1235, 1'b1, 16'h0000, 8'd0,  8'd0},   // R3 odd address
        '{2'd0, 1'b0, 16'h2000, 1'b1, 16'h0000, 8'd0,  8'd0},   // R3 code 0
        '{2'd1, 1'b1, 16'h0040, 1'b0, 16'h0040, 8'd8,  8'd0},   // R8 data-region program
        '{2'd2, 1'b0, 16'h0200, 1'b0, 16'h0200, 8'd0,  8'd20}   // R5 base already aligned
    };

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        do_reset();
        @(posedge clk); #1;
        // reset state
        chk("R7", "reset all_done", all_done, 1);
        chk("R6", "reset buf_empty", buf_empty, 1);
        chk("R1", "reset div_loaded", div_loaded, 0);
        chk("R4", "reset access_err", access_err, 0);
        chk("R13", "reset hv_en", hv_en, 0);

        // R2: request before divider load
        clr_mon();
        issue(2'd1, 1'b0, 16'h1000, 16'hAAAA);
        repeat (30) @(posedge clk); #1;
        chk("R2", "err before div load", access_err, 1);
        chk("R2", "no enable before div load", pgm_cyc + ers_cyc + hv_rises, 0);
        chk("R2", "still idle", all_done, 1);
        repeat (5) @(posedge clk); #1;
        chk("R4", "error sticky", access_err, 1);
        clear_err();
        chk("R4", "error cleared", access_err, 0);

        // R1: load divider, second write ignored
        write_div(8'h01);
        chk("R1", "div_loaded after write", div_loaded, 1);
        write_div(8'h47);

        // table walk
        for (int i = 0; i < NV; i++) begin
            clr_mon();
            issue(VECS[i].op, VECS[i].rg, VECS[i].addr, 16'h5A00 + 16'(i));
            if (VECS[i].exp_err) begin
                repeat (30) @(posedge clk); #1;
                chk("R3", $sformatf("vec%0d access_err", i), access_err, 1);
                chk("R3", $sformatf("vec%0d no enable", i), pgm_cyc + ers_cyc + hv_rises, 0);
                clear_err();
            end else begin
                wait_done();
                chk("R5", $sformatf("vec%0d addr", i), seen_addr, VECS[i].exp_addr);
                chk("R1", $sformatf("vec%0d program cycles", i), pgm_cyc, VECS[i].exp_pgm);
                chk("R8", $sformatf("vec%0d erase cycles", i), ers_cyc, VECS[i].exp_ers);
                chk("R8", $sformatf("vec%0d ramp-up cycles", i), hv_only, 6);
                chk("R8", $sformatf("vec%0d ramp-down+idle cycles", i), busy_nohv, 7);
                chk("R8", $sformatf("vec%0d hv rises", i), hv_rises, 1);
                chk("R4", $sformatf("vec%0d no error", i), access_err, 0);
            end
        end

        // R9: same-row burst
        clr_mon();
        issue(2'd1, 1'b0, 16'h1000, 16'h1111);
        issue(2'd1, 1'b0, 16'h1002, 16'h2222);
        chk("R6", "slot full after second accept", buf_empty, 0);
        chk("R7", "not done while queued", all_done, 0);
        wait_done();
        chk("R9", "burst hv rises", hv_rises, 1);
        chk("R9", "burst program cycles", pgm_cyc, 16);
        chk("R9", "burst single ramp-up", hv_only, 6);
        chk("R9", "burst last addr", seen_addr, 16'h1002);

        // R10: row change
        clr_mon();
        issue(2'd1, 1'b0, 16'h103E, 16'h3333);
        issue(2'd1, 1'b0, 16'h1040, 16'h4444);
        wait_done();
        chk("R10", "row change hv rises", hv_rises, 2);
        chk("R10", "row change ramp-up cycles", hv_only, 12);

        // R11: data region same row
        clr_mon();
        issue(2'd1, 1'b1, 16'h0100, 16'h5555);
        issue(2'd1, 1'b1, 16'h0102, 16'h6666);
        wait_done();
        chk("R11", "data region hv rises", hv_rises, 2);
        chk("R11", "data region program cycles", pgm_cyc, 16);

        // R12: program then erase
        clr_mon();
        issue(2'd1, 1'b0, 16'h2000, 16'h7777);
        issue(2'd2, 1'b0, 16'h2004, 16'h0000);
        wait_done();
        chk("R12", "erase after program hv rises", hv_rises, 2);
        chk("R12", "erase cycles", ers_cyc, 20);

        // R1: prescaler, D=0 with /8, bit7 set in write data
        do_reset();
        @(posedge clk); #1;
        write_div(8'hC0);
        clr_mon();
        issue(2'd1, 1'b0, 16'h0400, 16'h8888);
        wait_done();
        chk("R1", "prescaled program cycles", pgm_cyc, 32);
        chk("R1", "prescaled ramp-up cycles", hv_only, 24);

        finish_run();
    end

endmodule